// File: doc/BRIEF.md
# Line-Burst Memory Read Adapter

This block sits between a processor-side word port and a synchronous memory that only knows two kinds of access: an eight-word burst read of a whole line, and a single-word write. Every read the processor makes, even one uncached word, turns into a burst from the start of the line holding that word. The adapter then either hands back just the word that was asked for and drops the other seven, or streams the whole line back for a cache fill.

A third request kind serves a 16-byte DMA mover. With 16-bit words one line is exactly 16 bytes. When the DMA address starts a line, the request is served as a line stream. When it does not, the adapter splits it into eight separate one-word reads, and each of those still costs a full burst. Writes are never grouped: each one goes out as one memory command carrying its own address and data.

The processor port has a request strobe and a ready flag. Only one operation is in flight at a time. The memory answers a read command with eight data beats, the first one four cycles after the command, so each burst occupies twelve cycles.

Top module: `lineburst_port`

## Requirements
- R1: While reset is held, and in the first cycle after it, req_ready is 1 and mem_cmd_valid and rsp_valid are 0.
- R2: Every read command carries the requested address with its low three word-index bits forced to zero, so it is the first word of the eight-word line.
- R3: A read command appears in the cycle after the request is accepted. A burst spans twelve cycles: the command cycle, three latency cycles and eight data beats. req_ready returns exactly twelve cycles after acceptance, and two read commands are never closer than twelve cycles apart.
- R4: req_mode 2'b00 and 2'b11 are single-word reads. They give exactly one response, carrying the line word whose index equals req_addr[2:0], with rsp_last = 1, in the cycle after the eighth beat (twelve cycles after acceptance). The other seven words are dropped.
- R5: req_mode 2'b01 is a line fill. It gives eight responses on consecutive cycles, in ascending index order starting at index 0. Each response comes one cycle after its memory beat, the first five cycles after acceptance, and rsp_last is 1 only on the eighth.
- R6: A write (req_we = 1) issues exactly one memory command with mem_cmd_we = 1, the unmodified word address and the write data. It produces no response, and req_ready returns one cycle after acceptance.
- R7: req_mode 2'b10 with req_addr[2:0] == 0 is served exactly like a line fill: one burst and eight streamed words.
- R8: req_mode 2'b10 with req_addr[2:0] != 0 becomes eight single-word reads of req_addr, req_addr+1, ..., req_addr+7. Each is a full twelve-cycle burst, issued back to back, for 96 cycles in all. It gives one response per read, in that order, with rsp_last on the eighth only.
- R9: While an operation is in progress req_ready is 0, and a request presented then is ignored: it issues no memory command and changes no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request strobe |
| req_ready | output | 1 | Adapter idle; a request is taken on a clock edge where both are high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | Read kind: 00/11 one word, 01 line fill, 10 16-byte block |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data strobe |
| rsp_data | output | DW | Read data |
| rsp_last | output | 1 | Final word of the operation |
| mem_cmd_valid | output | 1 | Memory command strobe (one cycle) |
| mem_cmd_we | output | 1 | 1 = single-word write, 0 = eight-word burst read |
| mem_cmd_addr | output | AW | Command address |
| mem_cmd_wdata | output | DW | Write data to memory |
| mem_rd_valid | input | 1 | Memory read beat strobe |
| mem_rd_data | input | DW | Memory read beat data |

## Verification
The hardest case to reach is the unaligned 16-byte request whose eight words run past the end of a line. The stimulus starts such a request at index 3 near a line end, so the adapter must step its address across the boundary and rebase the later bursts. Single reads at index 7 and index 0 cover both ends of the word selection. At index 7 the chosen word arrives on the very beat that closes the burst. The case of a request arriving while the adapter is busy is built by holding a conflicting write request on the port in the middle of a burst, then reading the targeted word back.

// File: rtl/lbp_pkg.sv
package lbp_pkg;
  typedef enum logic [1:0] {
    M_WORD  = 2'b00,
    M_LINE  = 2'b01,
    M_BLK   = 2'b10,
    M_WORDX = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'b00,
    S_WR   = 2'b01,
    S_RD   = 2'b10
  } st_e;
endpackage

// File: rtl/lbp_addr.sv
module lbp_addr #(
  parameter int AW = 16,
  parameter int IW = 3
) (
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] cur_addr,
  output logic [AW-1:0] req_base,
  output logic          req_aligned,
  output logic [AW-1:0] nxt_addr,
  output logic [AW-1:0] nxt_base,
  output logic [IW-1:0] cur_idx
);
  // line base: clear the word-index bits
  assign req_base    = {req_addr[AW-1:IW], {IW{1'b0}}};
  assign req_aligned = (req_addr[IW-1:0] == '0);
  assign nxt_addr    = cur_addr + AW'(1);
  assign nxt_base    = {nxt_addr[AW-1:IW], {IW{1'b0}}};
  assign cur_idx     = cur_addr[IW-1:0];
endmodule

// File: rtl/lbp_seq.sv
module lbp_seq
  import lbp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int LW = 8,
  localparam int IW = $clog2(LW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [1:0]    req_mode,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [AW-1:0] req_base,
  input  logic          req_aligned,
  input  logic [AW-1:0] nxt_addr,
  input  logic [AW-1:0] nxt_base,
  input  logic          mem_rd_valid,
  output logic          req_ready,
  output logic          mem_cmd_valid,
  output logic          mem_cmd_we,
  output logic [AW-1:0] mem_cmd_addr,
  output logic [DW-1:0] mem_cmd_wdata,
  output logic [AW-1:0] cur_addr,
  output logic [IW-1:0] beat,
  output logic          stream,
  output logic          more,
  output logic          rd_on
);
  localparam logic [IW-1:0] LAST = IW'(LW - 1);

  st_e           st;
  logic [IW-1:0] left;
  logic          is_line, is_blk;

  assign is_line   = (req_mode == M_LINE);
  assign is_blk    = (req_mode == M_BLK);
  assign req_ready = (st == S_IDLE);
  assign rd_on     = (st == S_RD);
  assign more      = (left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      mem_cmd_valid <= 1'b0;
      mem_cmd_we    <= 1'b0;
      mem_cmd_addr  <= '0;
      mem_cmd_wdata <= '0;
      cur_addr      <= '0;
      beat          <= '0;
      stream        <= 1'b0;
      left          <= '0;
    end else begin
      mem_cmd_valid <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (req_valid) begin
            mem_cmd_valid <= 1'b1;
            mem_cmd_we    <= req_we;
            cur_addr      <= req_addr;
            beat          <= '0;
            if (req_we) begin
              mem_cmd_addr  <= req_addr;
              mem_cmd_wdata <= req_wdata;
              stream        <= 1'b0;
              left          <= '0;
              st            <= S_WR;
            end else begin
              mem_cmd_addr <= req_base;
              stream       <= is_line | (is_blk & req_aligned);
              left         <= (is_blk & ~req_aligned) ? LAST : '0;
              st           <= S_RD;
            end
          end
        end
        S_WR: st <= S_IDLE;
        S_RD: begin
          if (mem_rd_valid) begin
            beat <= beat + IW'(1);
            if (beat == LAST) begin
              if (left != '0) begin
                // fallback: next single word, again a whole burst
                left          <= left - IW'(1);
                cur_addr      <= nxt_addr;
                mem_cmd_valid <= 1'b1;
                mem_cmd_we    <= 1'b0;
                mem_cmd_addr  <= nxt_base;
              end else begin
                st <= S_IDLE;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lbp_pick.sv
module lbp_pick #(
  parameter int DW = 16,
  parameter int LW = 8,
  localparam int IW = $clog2(LW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_on,
  input  logic          stream,
  input  logic          more,
  input  logic [IW-1:0] beat,
  input  logic [IW-1:0] idx,
  input  logic          mem_rd_valid,
  input  logic [DW-1:0] mem_rd_data,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_last
);
  localparam logic [IW-1:0] LAST = IW'(LW - 1);

  logic [DW-1:0] hold;
  logic          take;

  assign take = rd_on & mem_rd_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_last  <= 1'b0;
      hold      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (take) begin
        if (beat == idx) hold <= mem_rd_data;
        if (stream) begin
          rsp_valid <= 1'b1;
          rsp_data  <= mem_rd_data;
          rsp_last  <= (beat == LAST);
        end else if (beat == LAST) begin
          rsp_valid <= 1'b1;
          rsp_data  <= (idx == LAST) ? mem_rd_data : hold;
          rsp_last  <= ~more;
        end
      end
    end
  end
endmodule

// File: rtl/lineburst_port.sv
module lineburst_port #(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int LINE_WORDS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [1:0]    req_mode,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_last,
  output logic          mem_cmd_valid,
  output logic          mem_cmd_we,
  output logic [AW-1:0] mem_cmd_addr,
  output logic [DW-1:0] mem_cmd_wdata,
  input  logic          mem_rd_valid,
  input  logic [DW-1:0] mem_rd_data
);
  localparam int IW = $clog2(LINE_WORDS);

  logic [AW-1:0] req_base, nxt_addr, nxt_base, cur_addr;
  logic          req_aligned, stream, more, rd_on;
  logic [IW-1:0] beat, cur_idx;

  lbp_addr #(.AW(AW), .IW(IW)) u_addr (
    .req_addr(req_addr), .cur_addr(cur_addr),
    .req_base(req_base), .req_aligned(req_aligned),
    .nxt_addr(nxt_addr), .nxt_base(nxt_base), .cur_idx(cur_idx)
  );

  lbp_seq #(.AW(AW), .DW(DW), .LW(LINE_WORDS)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_we(req_we), .req_mode(req_mode),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_base(req_base), .req_aligned(req_aligned),
    .nxt_addr(nxt_addr), .nxt_base(nxt_base),
    .mem_rd_valid(mem_rd_valid), .req_ready(req_ready),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_we(mem_cmd_we),
    .mem_cmd_addr(mem_cmd_addr), .mem_cmd_wdata(mem_cmd_wdata),
    .cur_addr(cur_addr), .beat(beat), .stream(stream),
    .more(more), .rd_on(rd_on)
  );

  lbp_pick #(.DW(DW), .LW(LINE_WORDS)) u_pick (
    .clk(clk), .rst(rst), .rd_on(rd_on), .stream(stream), .more(more),
    .beat(beat), .idx(cur_idx),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last)
  );
endmodule

// File: rtl/lbp_chk.sv
module lbp_chk #(
  parameter int LW  = 8,
  parameter int LAT = 4,
  localparam int IW   = $clog2(LW),
  localparam int SPAN = LAT + LW,
  localparam int GW   = $clog2(SPAN + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          cmd_valid,
  input logic          cmd_we,
  input logic [IW-1:0] cmd_lo,
  input logic          rd_valid,
  input logic          rsp_valid,
  input logic          rsp_last
);
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) gap <= GW'(SPAN);
    else if (cmd_valid && !cmd_we) gap <= GW'(1);
    else if (gap < GW'(SPAN)) gap <= gap + GW'(1);
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (req_ready && !cmd_valid && !rsp_valid));

  a_r2_line_base: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_we) |-> (cmd_lo == '0));

  a_r3_burst_spacing: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_we) |-> (gap >= GW'(SPAN)));

  a_r5_rsp_after_beat: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(rd_valid));

  a_r5_last_closes: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_last) |=> !rsp_valid);

  a_r6_write_lone: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_we) |=> !cmd_valid);

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind lineburst_port lbp_chk #(.LW(LINE_WORDS), .LAT(4)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_valid(mem_cmd_valid), .cmd_we(mem_cmd_we),
  .cmd_lo(mem_cmd_addr[$clog2(LINE_WORDS)-1:0]),
  .rd_valid(mem_rd_valid), .rsp_valid(rsp_valid), .rsp_last(rsp_last)
);

// File: tb/sim_lineburst_port.sv
module sim_lineburst_port;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int LW = 8;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_we = 1'b0;
  logic [1:0]    req_mode = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_last;
  logic [DW-1:0] rsp_data;
  logic          mem_cmd_valid, mem_cmd_we;
  logic [AW-1:0] mem_cmd_addr;
  logic [DW-1:0] mem_cmd_wdata;
  logic          mem_rd_valid;
  logic [DW-1:0] mem_rd_data;

  lineburst_port #(.AW(AW), .DW(DW), .LINE_WORDS(LW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int vec = 0, bad = 0, cyc = 0;
  bit done = 1'b0;
  string tag = "R1";

  function automatic logic [DW-1:0] pat(int i);
    return DW'(i * 16'h0101) ^ 16'h3C5A;
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h (t=%0t)", rq, act, exp, $time);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: burst beats at cmd+4 .. cmd+11, single-word writes
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] shadow [NW];
  logic [AW-1:0] mbase;
  int mcnt = 0, n_rd = 0, n_wr = 0, n_misal = 0;
  logic [AW-1:0] wr_addr_seen;
  logic [DW-1:0] wr_data_seen;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) mem[i] <= pat(i);
      mcnt <= 0;
      mem_rd_valid <= 1'b0;
      mem_rd_data <= '0;
      mbase <= '0;
    end else begin
      mem_rd_valid <= 1'b0;
      if (mem_cmd_valid) begin
        if (mem_cmd_we) begin
          mem[mem_cmd_addr] <= mem_cmd_wdata;
          wr_addr_seen <= mem_cmd_addr;
          wr_data_seen <= mem_cmd_wdata;
          n_wr = n_wr + 1;
        end else begin
          mbase <= mem_cmd_addr;
          n_rd = n_rd + 1;
          if (mem_cmd_addr[2:0] != 3'd0) n_misal = n_misal + 1;
        end
      end
      if (mcnt != 0) begin
        if (mcnt >= 3) begin
          mem_rd_valid <= 1'b1;
          mem_rd_data  <= mem[AW'(int'(mbase) + mcnt - 3)];
        end
        mcnt <= (mcnt == 10) ? 0 : mcnt + 1;
      end else if (mem_cmd_valid && !mem_cmd_we) begin
        mcnt <= 1;
      end
    end
  end

  // scoreboard monitor
  logic [DW:0] expq [$];
  int n_rsp = 0, first_rsp = -1, last_rsp = -1;

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      n_rsp = n_rsp + 1;
      if (first_rsp < 0) first_rsp = cyc;
      last_rsp = cyc;
      if (expq.size() == 0) begin
        chk(1'b0, tag, int'(rsp_data), -1);
      end else begin
        logic [DW:0] e;
        e = expq.pop_front();
        chk({rsp_last, rsp_data} == e, tag, int'({rsp_last, rsp_data}), int'(e));
      end
    end
  end

  task automatic push_word(int a, bit last);
    expq.push_back({last, shadow[a % NW]});
  endtask

  int acc, busy, rd0, wr0;

  task automatic run_op(bit we, logic [1:0] md, int a, logic [DW-1:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_mode = md;
    req_addr = AW'(a); req_wdata = wd;
    n_rsp = 0; first_rsp = -1; last_rsp = -1;
    rd0 = n_rd; wr0 = n_wr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    acc = cyc; busy = 0;
    while (!req_ready) begin
      busy++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic single_rd(logic [1:0] md, int a, string rq);
    tag = rq;
    push_word(a, 1'b1);
    run_op(1'b0, md, a, '0);
    chk(busy == 12, "R3 busy", busy, 12);
    chk(n_rd - rd0 == 1, "R2 one burst", n_rd - rd0, 1);
    chk(n_rsp == 1, {rq, " one rsp"}, n_rsp, 1);
    chk(first_rsp == acc + 12, {rq, " rsp cycle"}, first_rsp - acc, 12);
  endtask

  task automatic line_rd(logic [1:0] md, int a, string rq);
    int b;
    tag = rq;
    b = a & ~7;
    for (int k = 0; k < LW; k++) push_word(b + k, k == LW - 1);
    run_op(1'b0, md, a, '0);
    chk(busy == 12, "R3 busy", busy, 12);
    chk(n_rd - rd0 == 1, {rq, " one burst"}, n_rd - rd0, 1);
    chk(n_rsp == 8, {rq, " rsp count"}, n_rsp, 8);
    chk(first_rsp == acc + 5, {rq, " first beat"}, first_rsp - acc, 5);
    chk(last_rsp == acc + 12, {rq, " consecutive"}, last_rsp - acc, 12);
  endtask

  task automatic wr(int a, logic [DW-1:0] d);
    tag = "R6";
    shadow[a] = d;
    run_op(1'b1, 2'b00, a, d);
    chk(busy == 1, "R6 busy", busy, 1);
    chk(n_wr - wr0 == 1, "R6 write cmds", n_wr - wr0, 1);
    chk(n_rd - rd0 == 0, "R6 no read", n_rd - rd0, 0);
    chk(n_rsp == 0, "R6 no rsp", n_rsp, 0);
    chk(wr_addr_seen == AW'(a), "R6 addr", int'(wr_addr_seen), a);
    chk(wr_data_seen == d, "R6 data", int'(wr_data_seen), int'(d));
  endtask

  initial begin
    for (int i = 0; i < NW; i++) shadow[i] = pat(i);
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(mem_cmd_valid == 1'b0, "R1 cmd", int'(mem_cmd_valid), 0);
    chk(rsp_valid == 1'b0, "R1 rsp", int'(rsp_valid), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    single_rd(2'b00, 8'h13, "R4");
    single_rd(2'b00, 8'h2F, "R4");
    single_rd(2'b00, 8'h40, "R4");
    single_rd(2'b11, 8'h55, "R4");
    line_rd(2'b01, 8'h35, "R5");
    wr(8'h13, 16'hBEEF);
    single_rd(2'b00, 8'h13, "R4");
    wr(8'h62, 16'h1234);
    line_rd(2'b01, 8'h60, "R5");
    line_rd(2'b10, 8'h80, "R7");

    // R8: unaligned block, crossing a line end
    tag = "R8";
    for (int k = 0; k < LW; k++) push_word(8'h9B + k, k == LW - 1);
    run_op(1'b0, 2'b10, 8'h9B, '0);
    chk(busy == 96, "R8 busy", busy, 96);
    chk(n_rd - rd0 == 8, "R8 bursts", n_rd - rd0, 8);
    chk(n_rsp == 8, "R8 rsp count", n_rsp, 8);
    chk(first_rsp == acc + 12, "R8 first", first_rsp - acc, 12);
    chk(last_rsp == acc + 96, "R8 last", last_rsp - acc, 96);

    // R9: conflicting write presented while busy
    tag = "R9";
    push_word(8'h21, 1'b1);
    fork
      run_op(1'b0, 2'b00, 8'h21, '0);
      begin
        repeat (4) @(negedge clk);
        req_valid = 1'b1; req_we = 1'b1; req_addr = 8'h77; req_wdata = 16'hDEAD;
        repeat (5) @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
      end
    join
    chk(n_wr - wr0 == 0, "R9 no write", n_wr - wr0, 0);
    chk(n_rsp == 1, "R9 rsp count", n_rsp, 1);
    chk(mem[8'h77] == pat(8'h77), "R9 memory untouched", int'(mem[8'h77]), int'(pat(8'h77)));
    single_rd(2'b00, 8'h77, "R9");

    chk(n_misal == 0, "R2 aligned bursts", n_misal, 0);
    chk(expq.size() == 0, "R5 queue drained", expq.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule